// File: doc/BRIEF.md
# Serial Register Port with Burst Access

This block lets an external host read and write a bank of 8-bit control registers over a four-wire serial link: chip select (active low), serial clock, data in and data out. A transaction opens when chip select falls. The first byte carries a direction flag followed by a 7-bit register address. One or more data bytes follow. For as long as chip select stays low, each further byte moves to the next register address. Every byte in the transaction goes in the direction set by the first byte.

All state lives in the system clock domain. The three serial pins pass through a synchronizer, and the block detects serial clock edges by oversampling them. The serial clock must therefore be several times slower than the system clock. The whole register bank is also presented as one flat parallel vector, so the rest of the chip can use the settings directly.

Top module: `spi_regs_bank`

## Requirements
- R1: After reset every register reads 0x00 and the parallel view is all zeros.
- R2: The first bit after chip select falls is the direction flag (1 = read, 0 = write). The next 7 bits are the register address, MSB first. Data in is sampled on the rising serial clock edge.
- R3: In a write, the 8 bits that follow the address are the data, MSB first. After the 8th bit is received they replace register N, which appears at bits [8N+7:8N] of the parallel view.
- R4: In a read, data out presents the addressed register MSB first, changing on falling serial clock edges, so the first data bit is valid at the 9th rising edge. Data in is ignored during a read and no register changes.
- R5: In a write where chip select stays low, each further group of 8 bits is written to the next consecutive address.
- R6: In a read where chip select stays low, each further group of 8 clocks returns the register at the next consecutive address.
- R7: The burst address wraps from 127 to 0.
- R8: If chip select rises before all 8 bits of a write byte have arrived, that partial byte is discarded and the register keeps its old value.
- R9: A chip select rise at any point, including partway through the command byte, returns the block to the command phase. The next transaction is then decoded from its own first bit.
- R10: Data out is high-impedance while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host, high-impedance while deselected |
| regView | output | 1024 | Flat parallel copy of all 128 registers, register N at [8N+7:8N] |

## Verification
A bit counter that slips by one shows up as a shifted address or data value. Within the same transaction, the wrong register in the parallel view changes, or a byte arrives rotated by one position on data out. A stale pending-reload flag, or a direction flag that survives deselection, shows up no later than the next transaction. That transaction then returns bits from the wrong register or writes during a read. Burst and wrap tests expose an address stepper that fails to advance or to wrap: the third byte of a burst lands on, or returns, the wrong register.

// File: rtl/spi_regs_pkg.sv
`timescale 1ns/1ps
package spi_regs_pkg;

  // Single-cycle events from the sequencer to the datapath.
  typedef struct packed {
    logic captureBit;  // shift the sampled input bit in
    logic latchCmd;    // command byte complete: take the address
    logic commitByte;  // write byte complete: store it
    logic stepAddr;    // data byte finished: advance the address
    logic reloadOut;   // load the output shifter from the bank
    logic shiftOut;    // move the output shifter by one bit
  } spiStrobes_t;

endpackage

// File: rtl/spi_regs_sync.sv
`timescale 1ns/1ps
module spi_regs_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut,
  output logic [WIDTH-1:0] prevOut
);

  logic [WIDTH-1:0] chain [STAGES+1];

  assign chain[0] = asyncIn;

  for (genvar s = 0; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s+1] <= RST_VAL;
      else       chain[s+1] <= chain[s];
    end
  end

  assign syncOut = chain[STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevOut <= RST_VAL;
    else       prevOut <= syncOut;
  end

endmodule

// File: rtl/spi_regs_ctrl.sv
`timescale 1ns/1ps
module spi_regs_ctrl
  import spi_regs_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csActive,
  input  logic        sclkRise,
  input  logic        sclkFall,
  input  logic        cmdFlag,
  output spiStrobes_t strb
);

  localparam int CMD_BITS = ADDR_W + 1;
  localparam int MAX_BITS = (CMD_BITS > DATA_W) ? CMD_BITS : DATA_W;
  localparam int CNT_W = $clog2(MAX_BITS);

  logic [CNT_W-1:0] bitCnt;
  logic             inData;
  logic             isRead;
  logic             loadPend;
  logic             lastBit;

  assign lastBit = inData ? (bitCnt == CNT_W'(DATA_W - 1))
                          : (bitCnt == CNT_W'(CMD_BITS - 1));

  always_comb begin
    strb = '0;
    if (csActive && sclkRise) begin
      strb.captureBit = 1'b1;
      if (lastBit) begin
        if (!inData) begin
          strb.latchCmd = 1'b1;
        end else begin
          strb.commitByte = !isRead;
          strb.stepAddr = 1'b1;
        end
      end
    end
    if (csActive && sclkFall) begin
      if (loadPend) strb.reloadOut = 1'b1;
      else          strb.shiftOut = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      inData <= 1'b0;
      isRead <= 1'b0;
      loadPend <= 1'b0;
    end else if (!csActive) begin
      bitCnt <= '0;
      inData <= 1'b0;
      isRead <= 1'b0;
      loadPend <= 1'b0;
    end else if (sclkRise) begin
      if (lastBit) begin
        bitCnt <= '0;
        inData <= 1'b1;
        if (!inData) begin
          isRead <= cmdFlag;
          loadPend <= cmdFlag;
        end else begin
          loadPend <= isRead;
        end
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end else if (sclkFall && loadPend) begin
      loadPend <= 1'b0;
    end
  end

  AST_START_IN_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csActive) |-> !inData); // R9

  AST_READ_NO_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    isRead |-> !strb.commitByte); // R4

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.latchCmd, strb.commitByte, strb.reloadOut, strb.shiftOut})); // R2

endmodule

// File: rtl/spi_regs_dp.sv
`timescale 1ns/1ps
module spi_regs_dp
  import spi_regs_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             sdiBit,
  input  spiStrobes_t                      strb,
  output logic                             cmdFlag,
  output logic                             sdoBit,
  output logic [(2**ADDR_W)*DATA_W-1:0]    regView
);

  localparam int NUM_REGS = 2 ** ADDR_W;
  localparam int SH_W = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;

  logic [SH_W-1:0]   inShift;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] outShift;
  logic [DATA_W-1:0] newData;
  logic [DATA_W-1:0] regFile [NUM_REGS];

  assign cmdFlag = inShift[ADDR_W-1];
  assign newData = {inShift[DATA_W-2:0], sdiBit};
  assign sdoBit = outShift[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inShift <= '0;
    else if (strb.captureBit) inShift <= {inShift[SH_W-2:0], sdiBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addr <= '0;
    else if (strb.latchCmd) addr <= {inShift[ADDR_W-2:0], sdiBit};
    else if (strb.stepAddr) addr <= addr + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outShift <= '0;
    else if (strb.reloadOut) outShift <= regFile[addr];
    else if (strb.shiftOut) outShift <= {outShift[DATA_W-2:0], 1'b0};
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gBank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regFile[g] <= '0;
      else if (strb.commitByte && addr == ADDR_W'(g)) regFile[g] <= newData;
    end
    assign regView[g*DATA_W +: DATA_W] = regFile[g];
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepAddr |=> addr == $past(addr) + 1'b1); // R7

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commitByte |=> $stable(regView)); // R8

endmodule

// File: rtl/spi_regs_bank.sv
`timescale 1ns/1ps
module spi_regs_bank
  import spi_regs_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          csN,
  input  logic                          sclk,
  input  logic                          sdi,
  output logic                          sdo,
  output logic [(2**ADDR_W)*DATA_W-1:0] regView
);

  logic [2:0]  pinSync;
  logic [2:0]  pinPrev;
  logic        csActive;
  logic        sclkRise;
  logic        sclkFall;
  logic        cmdFlag;
  logic        sdoBit;
  spiStrobes_t strb;

  spi_regs_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (3),
    .RST_VAL(3'b100)
  ) uSync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({csN, sclk, sdi}),
    .syncOut(pinSync),
    .prevOut(pinPrev)
  );

  assign csActive = !pinSync[2];
  assign sclkRise = pinSync[1] && !pinPrev[1];
  assign sclkFall = !pinSync[1] && pinPrev[1];

  spi_regs_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .csActive(csActive),
    .sclkRise(sclkRise),
    .sclkFall(sclkFall),
    .cmdFlag (cmdFlag),
    .strb    (strb)
  );

  spi_regs_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .sdiBit (pinSync[0]),
    .strb   (strb),
    .cmdFlag(cmdFlag),
    .sdoBit (sdoBit),
    .regView(regView)
  );

  assign sdo = csN ? 1'bz : sdoBit;

endmodule

// File: tb/spi_regs_bank_test.sv
`timescale 1ns/1ps
module spi_regs_bank_test;

  localparam int HALF = 200;
  localparam int NVEC = 8;
  localparam logic [14:0] VECS [NVEC] = '{
    {7'd0,   8'hA5}, {7'd1,   8'h3C}, {7'd5,   8'hFF}, {7'd42,  8'h81},
    {7'd63,  8'h7E}, {7'd64,  8'h01}, {7'd100, 8'hC3}, {7'd127, 8'h5A}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  wire  sdo;
  logic [1023:0] regView;

  int checks = 0;
  int fails = 0;
  logic [7:0] model [128];
  logic [31:0] miso;

  spi_regs_bank uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .regView(regView)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic spiXfer(input int nBits, input logic [31:0] mosi, output logic [31:0] rx);
    rx = '0;
    csN = 1'b0;
    #HALF;
    for (int i = nBits - 1; i >= 0; i--) begin
      sdi = mosi[i];
      #HALF;
      rx = {rx[30:0], sdo};
      sclk = 1'b1;
      #HALF;
      sclk = 1'b0;
    end
    #HALF;
    csN = 1'b1;
    #(2 * HALF);
  endtask

  task automatic chkBank(input string req);
    for (int a = 0; a < 128; a++) chk(req, {24'd0, regView[a*8 +: 8]}, {24'd0, model[a]});
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < 128; a++) model[a] = 8'h00;
    #95;
    rstN = 1'b1;
    #100;
    // R1 reset contents, R10 idle data out
    chk("R1", {31'd0, (regView == '0)}, 32'd1);
    chk("R10", {31'd0, (sdo === 1'bz)}, 32'd1);

    // R2 R3: single writes from the vector table, flag 0 = write
    for (int v = 0; v < NVEC; v++) begin
      spiXfer(16, {16'd0, 1'b0, VECS[v]}, miso);
      model[VECS[v][14:8]] = VECS[v][7:0];
      chk("R3", {24'd0, regView[VECS[v][14:8]*8 +: 8]}, {24'd0, VECS[v][7:0]});
    end
    chkBank("R3");

    // R4: single reads, flag 1 = read, SDI toggling during data
    for (int v = 0; v < NVEC; v++) begin
      spiXfer(16, {16'd0, 1'b1, VECS[v][14:8], 8'h96}, miso);
      chk("R4", {24'd0, miso[7:0]}, {24'd0, VECS[v][7:0]});
    end
    chkBank("R4");
    chk("R10", {31'd0, (sdo === 1'bz)}, 32'd1);

    // R5 R7: burst write starting at 126 wraps to 0
    spiXfer(32, {1'b0, 7'd126, 8'h11, 8'h22, 8'h33}, miso);
    model[126] = 8'h11; model[127] = 8'h22; model[0] = 8'h33;
    chk("R5", {24'd0, regView[126*8 +: 8]}, 32'h11);
    chk("R5", {24'd0, regView[127*8 +: 8]}, 32'h22);
    chk("R7", {24'd0, regView[7:0]}, 32'h33);

    // R5: burst write in the middle of the map
    spiXfer(32, {1'b0, 7'd10, 8'hDE, 8'hAD, 8'hBE}, miso);
    model[10] = 8'hDE; model[11] = 8'hAD; model[12] = 8'hBE;
    chkBank("R5");

    // R6 R7: burst read across the wrap
    spiXfer(32, {1'b1, 7'd126, 24'hFFFFFF}, miso);
    chk("R6", {8'd0, miso[23:0]}, {8'd0, 8'h11, 8'h22, 8'h33});
    spiXfer(32, {1'b1, 7'd10, 24'h000000}, miso);
    chk("R6", {8'd0, miso[23:0]}, {8'd0, 8'hDE, 8'hAD, 8'hBE});
    chkBank("R6");

    // R8: partial byte discarded (one full byte, then 5 bits)
    spiXfer(21, {11'd0, 1'b0, 7'd20, 8'h44, 5'b10101}, miso);
    model[20] = 8'h44;
    chk("R8", {24'd0, regView[20*8 +: 8]}, 32'h44);
    chk("R8", {24'd0, regView[21*8 +: 8]}, 32'h00);
    spiXfer(12, {20'd0, 1'b0, 7'd5, 4'hF}, miso);
    chk("R8", {24'd0, regView[5*8 +: 8]}, 32'hFF);

    // R9: abort inside the command byte, then a clean write and read
    spiXfer(4, {28'd0, 4'b1011}, miso);
    spiXfer(16, {16'd0, 1'b0, 7'd33, 8'h9C}, miso);
    model[33] = 8'h9C;
    chk("R9", {24'd0, regView[33*8 +: 8]}, 32'h9C);
    spiXfer(3, {29'd0, 3'b111}, miso);
    spiXfer(16, {16'd0, 1'b1, 7'd33, 8'h00}, miso);
    chk("R9", {24'd0, miso[7:0]}, 32'h9C);
    chkBank("R9");
    chk("R10", {31'd0, (sdo === 1'bz)}, 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule